// File: doc/BRIEF.md
# Serial Display Command/Data Transmitter

This block drives a write-only four-wire serial link to a display controller. The four lines are an active-low chip select, a line that marks each byte as a command or as data, a serial clock and a serial data line. A request port with a valid/ready handshake starts one of three operations. The first sends a lone command byte. The second sends a command byte and then one data byte. The third opens a burst of data bytes, which are then supplied one by one on a second valid/ready channel that carries a last flag.

Each byte goes out most significant bit first. The block sets each bit on the data line while the serial clock is low and then raises the clock, so the receiver can capture the bit on the rising edge. A parameter gives the number of system clocks in each half of the serial clock period. The command/data line is steady across the whole byte, so it is valid at the rising edge of the eighth serial clock, where the receiver samples it. When an operation ends, all four lines return to their high idle level.

Top module: `disp_link_tx`

## Requirements
- R1: After a synchronous active-high reset, chip select, command/data, serial clock and serial data are all high, busy is low, the request channel is ready and the burst channel is not ready.
- R2: Each byte is sent as eight bits, most significant bit first. The data line holds its value across every rising edge of the serial clock while chip select is low.
- R3: With chip select low, every high phase of the serial clock lasts exactly HALF_CLKS system clocks. Every low phase lasts at least HALF_CLKS system clocks, and exactly HALF_CLKS when no burst byte is being waited for.
- R4: At the eighth rising serial clock edge of a byte, the command/data line is low (0) for a command byte and high (1) for a data byte.
- R5: Operation code 2'b00 sends the request's command byte as one framed transfer, with chip select low for that byte only.
- R6: Operation code 2'b01 sends the command byte in one frame and then the request's data byte in a second frame. Between the two frames all four lines are high for exactly HALF_CLKS system clocks.
- R7: An operation code with bit 1 set opens a burst. Data bytes are taken on the burst channel until a byte with the last flag is accepted. Chip select stays low across all the bytes, and a byte that is already offered starts right after the previous one with no extra delay.
- R8: If the next burst byte is not offered, the block holds chip select low and the serial clock low until a byte arrives.
- R9: Busy rises on the cycle after a request is accepted and stays high while chip select is low. The request channel is ready only while busy is low, and a request offered while busy is refused and sends nothing.
- R10: In the cycle where busy falls, all four lines are high.
- R11: The burst channel is ready only inside a burst. A byte offered on it at any other time is never taken and sends nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request channel can accept |
| req_op | input | 2 | 00 command, 01 command then data, 1x burst |
| req_cmd | input | BYTE_W | Command byte |
| req_data | input | BYTE_W | Data byte for the command-then-data operation |
| bst_valid | input | 1 | Burst byte offered |
| bst_ready | output | 1 | Burst byte can be taken |
| bst_data | input | BYTE_W | Burst data byte |
| bst_last | input | 1 | Offered burst byte is the final one |
| busy | output | 1 | An operation is in progress |
| dsp_cs_n | output | 1 | Chip select, active low |
| dsp_dc | output | 1 | Command (0) or data (1) marker |
| dsp_sck | output | 1 | Serial clock, idles high |
| dsp_sdo | output | 1 | Serial data, idles high |

## Verification
The hardest state to reach is the held middle of a burst. Here chip select stays low and the clock is parked low because no byte is offered, and the bytes on either side of the hold must still come out whole and in one frame. The stimulus reaches it by accepting one burst byte, withdrawing the burst channel for longer than a full byte time, and sampling the lines during the hold. It then supplies the rest. A bus monitor runs beside the stimulus and decodes the serial lines into bytes, command/data markers and frame numbers. The same monitor measures every clock phase and the idle gap between the two frames of a command-then-data operation.

// File: rtl/disp_link_pkg.sv
package disp_link_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } link_state_e;

    typedef struct packed {
        link_state_e st;
        logic        dc;
        logic        burst;
        logic        last;
        logic        pend;
    } link_ctl_t;

endpackage

// File: rtl/dlt_phase_timer.sv
module dlt_phase_timer #(
    parameter int HALF_CLKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(HALF_CLKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done_o = run_i && (cnt_q == LAST_CNT);
        if (!run_i || done_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R3: the phase counter never passes the half-period length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_CNT);

endmodule

// File: rtl/dlt_byte_shift.sv
module dlt_byte_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              shift_i,
    output logic              bit_o,
    output logic              final_o
);
    localparam int IW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(BYTE_W - 1);

    logic [BYTE_W-1:0] sh_d, sh_q;
    logic [IW-1:0]     idx_d, idx_q;

    always_comb begin
        sh_d  = sh_q;
        idx_d = idx_q;
        if (load_i) begin
            sh_d  = byte_i;
            idx_d = '0;
        end else if (shift_i) begin
            sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
            idx_d = idx_q + 1'b1;
        end
        bit_o   = sh_q[BYTE_W-1];
        final_o = (idx_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else begin
            sh_q  <= sh_d;
            idx_q <= idx_d;
        end
    end

    // R2: a load presents the top bit of the new byte first
    p_load_msb_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (idx_q == '0) && (bit_o == $past(byte_i[BYTE_W-1])));

    // R2: no shift is requested once the last bit is out
    p_no_overshift_r2: assert property (@(posedge clk) disable iff (rst)
        shift_i |-> !final_o);

endmodule

// File: rtl/disp_link_tx.sv
module disp_link_tx
    import disp_link_pkg::*;
#(
    parameter int HALF_CLKS = 3,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [BYTE_W-1:0] req_cmd,
    input  logic [BYTE_W-1:0] req_data,
    input  logic              bst_valid,
    output logic              bst_ready,
    input  logic [BYTE_W-1:0] bst_data,
    input  logic              bst_last,
    output logic              busy,
    output logic              dsp_cs_n,
    output logic              dsp_dc,
    output logic              dsp_sck,
    output logic              dsp_sdo
);
    link_ctl_t         ctl_d, ctl_q;
    logic [BYTE_W-1:0] pend_d, pend_q;
    logic              ph_run, ph_done;
    logic              ld, sh, cur_bit, fin;
    logic [BYTE_W-1:0] ld_byte;
    logic              line_idle;

    assign ph_run = (ctl_q.st == ST_LOW) || (ctl_q.st == ST_HIGH) || (ctl_q.st == ST_GAP);

    dlt_phase_timer #(.HALF_CLKS(HALF_CLKS)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (ph_run),
        .done_o (ph_done)
    );

    dlt_byte_shift #(.BYTE_W(BYTE_W)) i_shift (
        .clk     (clk),
        .rst     (rst),
        .load_i  (ld),
        .byte_i  (ld_byte),
        .shift_i (sh),
        .bit_o   (cur_bit),
        .final_o (fin)
    );

    always_comb begin
        ctl_d     = ctl_q;
        pend_d    = pend_q;
        ld        = 1'b0;
        sh        = 1'b0;
        ld_byte   = bst_data;
        bst_ready = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_op[1]) begin
                        ctl_d.st    = ST_WAIT;
                        ctl_d.dc    = 1'b1;
                        ctl_d.burst = 1'b1;
                        ctl_d.last  = 1'b0;
                        ctl_d.pend  = 1'b0;
                    end else begin
                        ld          = 1'b1;
                        ld_byte     = req_cmd;
                        ctl_d.st    = ST_LOW;
                        ctl_d.dc    = 1'b0;
                        ctl_d.burst = 1'b0;
                        ctl_d.pend  = req_op[0];
                        pend_d      = req_data;
                    end
                end
            end
            ST_WAIT: begin
                bst_ready = 1'b1;
                if (bst_valid) begin
                    ld         = 1'b1;
                    ctl_d.last = bst_last;
                    ctl_d.st   = ST_LOW;
                end
            end
            ST_LOW: begin
                if (ph_done) ctl_d.st = ST_HIGH;
            end
            ST_HIGH: begin
                if (ph_done) begin
                    if (!fin) begin
                        sh       = 1'b1;
                        ctl_d.st = ST_LOW;
                    end else if (ctl_q.burst && !ctl_q.last) begin
                        bst_ready = 1'b1;
                        if (bst_valid) begin
                            ld         = 1'b1;
                            ctl_d.last = bst_last;
                            ctl_d.st   = ST_LOW;
                        end else begin
                            ctl_d.st = ST_WAIT;
                        end
                    end else if (ctl_q.pend) begin
                        ctl_d.st = ST_GAP;
                    end else begin
                        ctl_d.st = ST_IDLE;
                    end
                end
            end
            ST_GAP: begin
                if (ph_done) begin
                    ld         = 1'b1;
                    ld_byte    = pend_q;
                    ctl_d.dc   = 1'b1;
                    ctl_d.pend = 1'b0;
                    ctl_d.st   = ST_LOW;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.dc    <= 1'b1;
            ctl_q.burst <= 1'b0;
            ctl_q.last  <= 1'b0;
            ctl_q.pend  <= 1'b0;
            pend_q      <= '0;
        end else begin
            ctl_q  <= ctl_d;
            pend_q <= pend_d;
        end
    end

    assign line_idle = (ctl_q.st == ST_IDLE) || (ctl_q.st == ST_GAP);
    assign busy      = (ctl_q.st != ST_IDLE);
    assign req_ready = !busy;
    assign dsp_cs_n  = line_idle;
    assign dsp_sck   = line_idle || (ctl_q.st == ST_HIGH);
    assign dsp_sdo   = line_idle || cur_bit;
    assign dsp_dc    = line_idle || ctl_q.dc;

    // R9: an accepted request makes the block busy
    p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> busy);

    // R9: chip select is only asserted during an operation
    p_cs_in_busy_r9: assert property (@(posedge clk) disable iff (rst)
        !dsp_cs_n |-> busy);

    // R10: all lines are idle high when busy drops
    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (dsp_cs_n && dsp_sck && dsp_sdo && dsp_dc));

    // R8: a missing burst byte parks the link with select and clock low
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (bst_ready && !bst_valid) |=> (!dsp_cs_n && !dsp_sck));

    // R2: the data level is settled before the clock rises
    p_sdo_setup_r2: assert property (@(posedge clk) disable iff (rst)
        (!dsp_cs_n && $rose(dsp_sck)) |-> $stable(dsp_sdo));

    // R11: the burst channel is closed outside a burst
    p_bst_closed_r11: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.burst |-> !bst_ready);

endmodule

// File: tb/test_disp_link_tx.sv
module test_disp_link_tx;
    localparam int HALF = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_op = 2'b00;
    logic [7:0] req_cmd = '0;
    logic [7:0] req_data = '0;
    logic       bst_valid = 1'b0;
    logic       bst_ready;
    logic [7:0] bst_data = '0;
    logic       bst_last = 1'b0;
    logic       busy;
    logic       cs_n, dc, sck, sdo;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    disp_link_tx #(.HALF_CLKS(HALF), .BYTE_W(8)) i_disp_link_tx (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_cmd(req_cmd), .req_data(req_data),
        .bst_valid(bst_valid), .bst_ready(bst_ready),
        .bst_data(bst_data), .bst_last(bst_last),
        .busy(busy),
        .dsp_cs_n(cs_n), .dsp_dc(dc), .dsp_sck(sck), .dsp_sdo(sdo)
    );

    // ---------------- line monitor ----------------
    logic [7:0] rx_byte [16];
    logic       rx_dc   [16];
    int         rx_frame[16];
    int  rx_n = 0, frame = 0, nbits = 0, gap_cnt = 0;
    int  hi_run = 0, lo_run = 0;
    int  mon_err = 0;
    bit  saw_bst_rdy = 1'b0;
    logic [7:0] cur = '0;
    logic p_cs = 1'b1, p_sck = 1'b1, p_busy = 1'b0;

    task automatic mon_clear();
        rx_n = 0; frame = 0; nbits = 0; gap_cnt = 0; mon_err = 0;
        saw_bst_rdy = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (bst_ready) saw_bst_rdy = 1'b1;
            if (busy && cs_n) gap_cnt++;
            if (!cs_n && !p_cs && sck && !p_sck) begin
                if (lo_run < HALF) mon_err++;
                lo_run = 0;
                cur = {cur[6:0], sdo};
                nbits++;
                if (nbits % 8 == 0 && rx_n < 16) begin
                    rx_byte[rx_n] = cur; rx_dc[rx_n] = dc; rx_frame[rx_n] = frame;
                    rx_n++;
                end
            end
            if (!p_cs && !cs_n && !sck && p_sck) begin
                if (hi_run != HALF) mon_err++;
                hi_run = 0;
            end
            if (!p_cs && cs_n) begin
                if (hi_run != HALF || nbits % 8 != 0) mon_err++;
                if (!(sck && sdo && dc)) mon_err++;
                hi_run = 0; lo_run = 0; frame++;
            end
            if (!cs_n && sck) hi_run++;
            if (!cs_n && !sck) lo_run++;
            if (p_busy && !busy && !(cs_n && sck && sdo && dc)) mon_err++;
            p_cs = cs_n; p_sck = sck; p_busy = busy;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_req(input logic [1:0] op, input logic [7:0] c, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_cmd = c; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic feed(input logic [7:0] d, input logic l);
        bst_valid = 1'b1; bst_data = d; bst_last = l;
        while (!bst_ready) @(negedge clk);
        @(negedge clk);
        bst_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_byte(input int i, input logic [7:0] b, input logic d,
                            input int f, input string req);
        chk(rx_byte[i] == b, req, "byte value", int'(rx_byte[i]), int'(b));
        chk(rx_dc[i] == d, "R4", "dc at 8th edge", int'(rx_dc[i]), int'(d));
        chk(rx_frame[i] == f, req, "frame index", rx_frame[i], f);
    endtask

    task automatic chk_idle_lines(input string req);
        chk(cs_n && dc && sck && sdo, req, "idle lines {cs,dc,sck,sdo}",
            int'({cs_n, dc, sck, sdo}), 4'hF);
        chk(mon_err == 0, "R3", "phase/frame monitor errors", mon_err, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();   // R1
        chk(cs_n && dc && sck && sdo, "R1", "lines after reset",
            int'({cs_n, dc, sck, sdo}), 4'hF);
        chk(!busy, "R1", "busy after reset", int'(busy), 0);
        chk(req_ready, "R1", "req_ready after reset", int'(req_ready), 1);
        chk(!bst_ready, "R1", "bst_ready after reset", int'(bst_ready), 0);
    endtask

    task automatic t_cmd();     // R5, R2
        mon_clear();
        send_req(2'b00, 8'hA5, 8'h00);
        chk(busy && !req_ready, "R9", "busy after accept", int'(busy), 1);
        wait_idle();
        chk(rx_n == 1 && frame == 1, "R5", "bytes/frames", rx_n * 16 + frame, 17);
        chk_byte(0, 8'hA5, 1'b0, 0, "R5");
        chk_idle_lines("R10");
    endtask

    task automatic t_cmd_data(); // R6
        mon_clear();
        send_req(2'b01, 8'h3C, 8'h81);
        wait_idle();
        chk(rx_n == 2 && frame == 2, "R6", "bytes/frames", rx_n * 16 + frame, 34);
        chk_byte(0, 8'h3C, 1'b0, 0, "R6");
        chk_byte(1, 8'h81, 1'b1, 1, "R6");
        chk(gap_cnt == HALF, "R6", "idle gap between frames", gap_cnt, HALF);
        chk_idle_lines("R10");
    endtask

    task automatic t_burst();   // R7, R2 (MSB first with 80/01)
        mon_clear();
        send_req(2'b10, 8'h00, 8'h00);
        feed(8'h80, 1'b0);
        bst_valid = 1'b1; bst_data = 8'h01; bst_last = 1'b0;
        while (!bst_ready) @(negedge clk);
        @(negedge clk);
        bst_data = 8'hF0; bst_last = 1'b1;
        while (!bst_ready) @(negedge clk);
        @(negedge clk);
        bst_valid = 1'b0;
        wait_idle();
        chk(rx_n == 3 && frame == 1, "R7", "bytes/frames", rx_n * 16 + frame, 49);
        chk_byte(0, 8'h80, 1'b1, 0, "R7");
        chk_byte(1, 8'h01, 1'b1, 0, "R2");
        chk_byte(2, 8'hF0, 1'b1, 0, "R7");
        chk_idle_lines("R10");
    endtask

    task automatic t_stall();   // R8
        mon_clear();
        send_req(2'b11, 8'h00, 8'h00);
        repeat (10) @(negedge clk);
        chk(!cs_n == 1'b1 && !sck, "R8", "held before first byte {cs_n,sck}",
            int'({cs_n, sck}), 0);
        feed(8'h5A, 1'b0);
        repeat (80) @(negedge clk);
        chk(!cs_n && !sck && busy, "R8", "held mid-burst {cs_n,sck,busy}",
            int'({cs_n, sck, busy}), 1);
        feed(8'hC3, 1'b1);
        wait_idle();
        chk(rx_n == 2 && frame == 1, "R8", "bytes/frames", rx_n * 16 + frame, 33);
        chk_byte(0, 8'h5A, 1'b1, 0, "R8");
        chk_byte(1, 8'hC3, 1'b1, 0, "R8");
        chk_idle_lines("R10");
    endtask

    task automatic t_refuse();  // R9
        mon_clear();
        send_req(2'b00, 8'h96, 8'h00);
        repeat (4) @(negedge clk);
        req_valid = 1'b1; req_op = 2'b01; req_cmd = 8'h11; req_data = 8'h22;
        chk(!req_ready, "R9", "req_ready while busy", int'(req_ready), 0);
        repeat (10) @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        chk(rx_n == 1 && frame == 1, "R9", "refused request sent nothing",
            rx_n * 16 + frame, 17);
        chk_byte(0, 8'h96, 1'b0, 0, "R9");
    endtask

    task automatic t_stray();   // R11
        mon_clear();
        bst_valid = 1'b1; bst_data = 8'hEE; bst_last = 1'b1;
        repeat (5) @(negedge clk);
        send_req(2'b00, 8'h0F, 8'h00);
        wait_idle();
        repeat (5) @(negedge clk);
        bst_valid = 1'b0;
        chk(!saw_bst_rdy, "R11", "bst_ready outside burst", int'(saw_bst_rdy), 0);
        chk(rx_n == 1 && frame == 1, "R11", "stray byte sent nothing",
            rx_n * 16 + frame, 17);
        chk_byte(0, 8'h0F, 1'b0, 0, "R11");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cmd();
        t_cmd_data();
        t_burst();
        t_stall();
        t_refuse();
        t_stray();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

endmodule